// File: doc/BRIEF.md
# Trial-Multiply Sequential Integer Divider

This block divides an 8-bit dividend by an 8-bit divisor. Each operand arrives as a magnitude with its own sign flag. The core works only on magnitudes and finds the quotient one bit per clock, starting at the most significant position. In each step the bit under test is set in a trial quotient. The divisor is multiplied by that whole trial quotient, and the product is subtracted from the dividend. If the signed difference is zero or above, the bit is kept. If it is below zero, the bit is cleared. The last accepted difference is the remainder, so no separate remainder path is needed.

A sign stage sits around the core and gives truncating division. The quotient is marked negative when exactly one operand is negative. The remainder follows the sign of the dividend. A zero divisor skips the iterations and returns a fixed pattern with a flag.

A user pulses `startValid` with the operands while the block is idle. The result appears together with a one-cycle `doneValid` pulse, and the outputs hold until the next result.

Top module: `mul_sub_divider`

## Requirements
- R1: A start is accepted on a rising edge where `startValid` is high and the block is idle. For a non-zero divisor, `doneValid` is high for exactly the cycle that follows the 8th rising edge after the accepting edge.
- R2: For a non-zero divisor, `quotMag` equals the dividend magnitude divided by the divisor magnitude, rounded down. A trial difference of exactly zero keeps the tested bit.
- R3: For a non-zero divisor, `remMag` equals dividendMag − divisorMag × quotMag.
- R4: The trial product and difference are signed and at least 17 bits wide, so trial products far above the dividend never wrap. Examples: 255/255 gives 1 r 0, 1/255 gives 0 r 1, and 255/1 gives 255 r 0.
- R5: For a non-zero divisor, `remMag` is below `divisorMag`.
- R6: For a non-zero divisor, `quotNeg` = dividendNeg XOR divisorNeg, forced to 0 when `quotMag` is 0.
- R7: `remNeg` = dividendNeg, forced to 0 when `remMag` is 0. This holds for every result, including divide by zero.
- R8: A divisor magnitude of 0 is decided in a single cycle. `doneValid` rises in the cycle after the first rising edge after acceptance, with `divZero`=1, `quotMag`=8'hFF, `quotNeg`=0 and `remMag` = the dividend magnitude. `divZero` is 0 on every other result.
- R9: A `startValid` pulse seen while a division is running has no effect: that division's result is unchanged and no extra `doneValid` pulse appears.
- R10: After reset, `doneValid`, `quotMag`, `remMag`, `quotNeg`, `remNeg` and `divZero` are 0. Between `doneValid` pulses all result outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Request a division with the operands below |
| dividendMag | input | 8 | Dividend magnitude |
| dividendNeg | input | 1 | Dividend is negative |
| divisorMag | input | 8 | Divisor magnitude |
| divisorNeg | input | 1 | Divisor is negative |
| doneValid | output | 1 | One-cycle pulse: result outputs are new |
| quotMag | output | 8 | Quotient magnitude |
| quotNeg | output | 1 | Quotient is negative |
| remMag | output | 8 | Remainder magnitude |
| remNeg | output | 1 | Remainder is negative |
| divZero | output | 1 | Divisor was zero |

## Verification
The bench targets several corner cases and the failure each one would show:
- Trial products far above the dividend, such as 1/255 and 255/255. A narrow or unsigned difference would wrap there and keep bits that should be cleared.
- Exact multiples, such as 100/10 and 128/128. A core that treated a zero difference as negative would come out one short in the quotient and one divisor high in the remainder.
- Mixed signs and zero results, such as −6/3 and 0/−5. A faulty sign stage would flag a zero quotient or remainder as negative, or would give the remainder the divisor's sign.
- A zero divisor, a second start in the middle of a run, and a new start issued in the very cycle of a result. These expose a wrong latency, a restart that corrupts the running division, or a lost request.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef struct packed {
    logic load;     // capture operands, clear trial state
    logic step;     // decide one quotient bit
    logic finish;   // write the result registers
    logic zeroDiv;  // result is the divide-by-zero pattern
  } divCtrl_t;
endpackage

// File: rtl/div_control.sv
module div_control
  import div_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CNTW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startValid,
  input  logic            divisorZero,
  output divCtrl_t        ctrl,
  output logic [CNTW-1:0] bitPos
);
  typedef enum logic [1:0] {StIdle, StRun, StZero} divState_t;
  divState_t state;

  always_comb begin
    ctrl         = '0;
    ctrl.load    = (state == StIdle) && startValid;
    ctrl.step    = (state == StRun);
    ctrl.zeroDiv = (state == StZero);
    ctrl.finish  = ((state == StRun) && (bitPos == '0)) || (state == StZero);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= StIdle;
      bitPos <= '0;
    end else begin
      unique case (state)
        StIdle: if (startValid) begin
          state  <= divisorZero ? StZero : StRun;
          bitPos <= CNTW'(WIDTH - 1);
        end
        StRun: if (bitPos == '0) state <= StIdle;
               else bitPos <= bitPos - 1'b1;
        StZero: state <= StIdle;
        default: state <= StIdle;
      endcase
    end
  end

  // R1: a running division walks down one bit position per clock
  assert_bit_walk_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == StRun && bitPos != '0) |=> (state == StRun && bitPos == $past(bitPos) - 1'b1));

  // R9: a start during a run does not send the control back to the top bit
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == StRun && bitPos != '0 && startValid) |=> (bitPos != CNTW'(WIDTH - 1)));
endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int CNTW  = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int DIFFW = 2 * WIDTH + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtrl_t         ctrl,
  input  logic [CNTW-1:0]  bitPos,
  input  logic [WIDTH-1:0] dividendMag,
  input  logic             dividendNeg,
  input  logic [WIDTH-1:0] divisorMag,
  input  logic             divisorNeg,
  output logic             doneValid,
  output logic [WIDTH-1:0] quotMag,
  output logic             quotNeg,
  output logic [WIDTH-1:0] remMag,
  output logic             remNeg,
  output logic             divZero
);
  logic [WIDTH-1:0] nReg, dReg, qReg;
  logic             nNegReg, dNegReg;
  logic [DIFFW-1:0] accDiff;      // dividend minus divisor times accepted quotient

  logic [WIDTH-1:0] trialQ, nextQ;
  logic [DIFFW-1:0] trialProd, trialDiff, nextAcc;
  logic             keepBit;

  always_comb begin
    trialQ    = qReg | (WIDTH'(1) << bitPos);
    trialProd = DIFFW'(dReg) * DIFFW'(trialQ);
    trialDiff = DIFFW'(nReg) - trialProd;
    keepBit   = !trialDiff[DIFFW-1];
    nextQ     = keepBit ? trialQ : qReg;
    nextAcc   = keepBit ? trialDiff : accDiff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nReg <= '0; dReg <= '0; qReg <= '0;
      nNegReg <= 1'b0; dNegReg <= 1'b0;
      accDiff <= '0;
      doneValid <= 1'b0;
      quotMag <= '0; quotNeg <= 1'b0;
      remMag <= '0; remNeg <= 1'b0;
      divZero <= 1'b0;
    end else begin
      doneValid <= ctrl.finish;
      if (ctrl.load) begin
        nReg    <= dividendMag;
        dReg    <= divisorMag;
        nNegReg <= dividendNeg;
        dNegReg <= divisorNeg;
        qReg    <= '0;
        accDiff <= DIFFW'(dividendMag);
      end else if (ctrl.step) begin
        qReg    <= nextQ;
        accDiff <= nextAcc;
      end
      if (ctrl.finish) begin
        if (ctrl.zeroDiv) begin
          quotMag <= '1;
          quotNeg <= 1'b0;
          remMag  <= nReg;
          remNeg  <= nNegReg && (nReg != '0);
          divZero <= 1'b1;
        end else begin
          quotMag <= nextQ;
          quotNeg <= (nNegReg ^ dNegReg) && (nextQ != '0);
          remMag  <= nextAcc[WIDTH-1:0];
          remNeg  <= nNegReg && (nextAcc[WIDTH-1:0] != '0);
          divZero <= 1'b0;
        end
      end
    end
  end

  // R4: the accepted difference never goes below zero during a run
  assert_acc_nonneg_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |-> !accDiff[DIFFW-1]);

  // R3: the result satisfies quotient times divisor plus remainder equals dividend
  assert_identity_R3: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !divZero) |->
      (DIFFW'(quotMag) * DIFFW'(dReg) + DIFFW'(remMag) == DIFFW'(nReg)));

  // R5: the remainder is below the divisor
  assert_rem_below_R5: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !divZero) |-> (remMag < dReg));

  // R6: the quotient sign follows the operand signs
  assert_quot_sign_R6: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !divZero) |-> (quotNeg == ((nNegReg ^ dNegReg) && quotMag != '0)));

  // R8: the zero-divisor pattern
  assert_zero_pattern_R8: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && divZero) |-> (quotMag == '1 && !quotNeg && remMag == nReg && dReg == '0));

  // R10: results hold between pulses
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.finish |=> ($stable(quotMag) && $stable(remMag) && $stable(divZero)));
endmodule

// File: rtl/mul_sub_divider.sv
module mul_sub_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [WIDTH-1:0] dividendMag,
  input  logic             dividendNeg,
  input  logic [WIDTH-1:0] divisorMag,
  input  logic             divisorNeg,
  output logic             doneValid,
  output logic [WIDTH-1:0] quotMag,
  output logic             quotNeg,
  output logic [WIDTH-1:0] remMag,
  output logic             remNeg,
  output logic             divZero
);
  localparam int CNTW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  divCtrl_t        ctrl;
  logic [CNTW-1:0] bitPos;

  div_control #(.WIDTH(WIDTH)) uControl (
    .clk         (clk),
    .rstN        (rstN),
    .startValid  (startValid),
    .divisorZero (divisorMag == '0),
    .ctrl        (ctrl),
    .bitPos      (bitPos)
  );

  div_datapath #(.WIDTH(WIDTH)) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .bitPos      (bitPos),
    .dividendMag (dividendMag),
    .dividendNeg (dividendNeg),
    .divisorMag  (divisorMag),
    .divisorNeg  (divisorNeg),
    .doneValid   (doneValid),
    .quotMag     (quotMag),
    .quotNeg     (quotNeg),
    .remMag      (remMag),
    .remNeg      (remNeg),
    .divZero     (divZero)
  );
endmodule

// File: tb/mul_sub_divider_test.sv
module mul_sub_divider_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic [7:0] dividendMag = '0, divisorMag = '0;
  logic       dividendNeg = 1'b0, divisorNeg = 1'b0;
  logic       doneValid, quotNeg, remNeg, divZero;
  logic [7:0] quotMag, remMag;

  mul_sub_divider uut (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .dividendMag(dividendMag), .dividendNeg(dividendNeg),
    .divisorMag(divisorMag), .divisorNeg(divisorNeg),
    .doneValid(doneValid), .quotMag(quotMag), .quotNeg(quotNeg),
    .remMag(remMag), .remNeg(remNeg), .divZero(divZero)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    int    q, r, d;
    bit    qn, rn, z;
    int    doneCyc;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  cyc = 0;
  int  compared = 0, mismatched = 0;
  bit  monOn = 1'b0;
  bit  haveLast = 1'b0;
  int  lastQ = 0, lastR = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (monOn) begin
      if (doneValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R9", "unexpected doneValid", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(cyc == e.doneCyc, e.z ? "R8" : "R1", "done cycle", cyc, e.doneCyc);
          chk(int'(quotMag) == e.q, e.tag, "quotient", int'(quotMag), e.q);
          chk(int'(remMag) == e.r, e.z ? "R8" : "R3", "remainder", int'(remMag), e.r);
          chk(quotNeg == e.qn, e.z ? "R8" : "R6", "quotient sign", int'(quotNeg), int'(e.qn));
          chk(remNeg == e.rn, "R7", "remainder sign", int'(remNeg), int'(e.rn));
          chk(divZero == e.z, "R8", "divZero", int'(divZero), int'(e.z));
          if (!e.z)
            chk(int'(remMag) < e.d, "R5", "remainder below divisor", int'(remMag), e.d);
          lastQ = int'(quotMag);
          lastR = int'(remMag);
          haveLast = 1'b1;
        end
      end else if (haveLast) begin
        chk(int'(quotMag) == lastQ && int'(remMag) == lastR, "R10", "hold quotient",
            int'(quotMag), lastQ);
      end
    end
  end

  // driver: start one division, push its expectation, return on the done cycle
  task automatic doDiv(input int n, input bit nn, input int d, input bit dn,
                       input string tag, input bit inject);
    expItem_t e;
    int lat;
    lat = (d == 0) ? 1 : 8;
    @(negedge clk);
    dividendMag = 8'(n); dividendNeg = nn;
    divisorMag  = 8'(d); divisorNeg  = dn;
    startValid  = 1'b1;
    e.d = d;
    e.z = (d == 0);
    e.q = e.z ? 255 : n / d;
    e.r = e.z ? n : n % d;
    e.qn = !e.z && (nn ^ dn) && (e.q != 0);
    e.rn = nn && (e.r != 0);
    e.doneCyc = cyc + 1 + lat;
    e.tag = e.z ? "R8" : tag;
    expQ.push_back(e);
    @(negedge clk);
    startValid = 1'b0;
    if (inject && lat == 8) begin
      @(negedge clk);
      dividendMag = 8'd7; divisorMag = 8'd0; dividendNeg = 1'b1; divisorNeg = 1'b0;
      startValid = 1'b1;                     // R9: must be ignored
      @(negedge clk);
      startValid = 1'b0;
      repeat (lat - 3) @(negedge clk);
    end else begin
      repeat (lat - 1) @(negedge clk);
    end
  endtask

  // watchdog
  initial begin
    #1600000;
    chk(1'b0, "R1", "watchdog expired", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int unsigned lcg;
    lcg = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!doneValid && quotMag == 0 && remMag == 0, "R10", "reset results", int'(quotMag), 0);
    chk(!quotNeg && !remNeg && !divZero, "R10", "reset flags", int'(divZero), 0);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;

    doDiv(200, 0, 7, 0, "R2", 0);
    doDiv(100, 0, 10, 0, "R2", 0);     // exact: zero difference keeps bit
    doDiv(128, 0, 128, 0, "R2", 0);
    doDiv(255, 0, 255, 0, "R4", 0);
    doDiv(1, 0, 255, 0, "R4", 0);
    doDiv(255, 0, 1, 0, "R4", 0);
    doDiv(0, 0, 5, 1, "R2", 0);
    doDiv(7, 1, 2, 0, "R2", 0);        // -7/2 = -3 r -1
    doDiv(7, 0, 2, 1, "R2", 0);        // 7/-2 = -3 r 1
    doDiv(6, 1, 3, 0, "R2", 0);        // -6/3 = -2 r 0
    doDiv(3, 1, 9, 1, "R2", 0);
    doDiv(13, 1, 0, 0, "R8", 0);
    doDiv(0, 1, 0, 1, "R8", 0);
    doDiv(250, 0, 3, 0, "R9", 1);      // start injected mid-run
    doDiv(99, 1, 4, 1, "R9", 1);
    // back-to-back: next start issued in the done cycle
    doDiv(77, 0, 5, 0, "R1", 0);
    doDiv(42, 0, 0, 0, "R8", 0);
    doDiv(42, 1, 6, 0, "R1", 0);

    for (int i = 0; i < 400; i++) begin
      int n, d;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      n = int'(lcg[23:16]);
      d = (lcg[3:0] == 4'd0) ? 0 : int'(lcg[31:24]);
      doDiv(n, lcg[8], d, lcg[9], "R2", lcg[10]);
    end

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "R1", "results outstanding", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule